// File: doc/BRIEF.md
# Critical-Word-First Line Refill Controller

After a read miss, this block refills one cache line from a lower memory level. In its wrapped mode it asks memory for the missed word first. It then asks for the other words of the line in ascending order, wrapping past the end of the line back to word zero. When the missed word comes back, the block passes it straight to the CPU with a one-cycle ready pulse. The CPU can therefore resume while the other words are still arriving. A second mode asks for the words in plain ascending order and still releases the CPU on the missed word's beat.

Each returned beat lands in its own slot of an internal line buffer. After the final beat, the block presents the whole line together with its tag and set index for one cycle, and the surrounding cache writes it and marks it valid at that point. While a fill is running, the block ignores new misses. A probe input reports a stall when a lookup targets the line being filled. With the default parameters, a line holds eight 32-bit words (32 bytes), so address bits [4:2] select the word, bits [11:5] are the set and bits [31:12] are the tag.

Top module: `cwf_fill_ctrl`

## Requirements
- R1: In wrapped mode (`miss_wrap`=1), the first request of a fill addresses the missed word, taken from `miss_addr[4:2]`.
- R2: `cpu_ready` is high for exactly one cycle per fill. That cycle is the one in which the missed word is on `mem_rsp_data`, and `cpu_data` carries that word. This comes before `fill_valid`.
- R3: In wrapped mode, the k-th request (k = 0..7) addresses word (critical + k) mod 8.
- R4: In natural mode (`miss_wrap`=0), the requests address words 0 to 7 in ascending order. `cpu_ready` still marks the beat that carries the missed word.
- R5: Exactly eight requests are issued, one per cycle, in the eight cycles that follow the accepting clock edge. Each request address is the line base plus four times the word index, with bits [1:0] equal to zero.
- R6: Memory returns beats in request order. Beat k is stored at the word position of request k, and `fill_line[32*i+31:32*i]` holds word i.
- R7: `fill_valid` pulses for one cycle, in the cycle after the eighth beat is taken. In that cycle `fill_tag`=`miss_addr[31:12]`, `fill_set`=`miss_addr[11:5]`, and `busy` is already low.
- R8: `busy` rises in the cycle after a miss is accepted. A `miss_valid` seen while `busy` is high is ignored and produces no requests.
- R9: `probe_stall` is high when `probe_valid` is high, `busy` is high and `probe_addr[31:5]` equals the line being filled. Otherwise it is low.
- R10: Cycles with `mem_rsp_valid` low between beats are tolerated. Order, placement and the single ready pulse are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| miss_valid | input | 1 | Read miss offered |
| miss_addr | input | 32 | Byte address of the missed word |
| miss_wrap | input | 1 | 1 = critical word first, 0 = natural order |
| busy | output | 1 | Fill in progress |
| mem_req_valid | output | 1 | Word request to lower memory |
| mem_req_addr | output | 32 | Word-aligned request address |
| mem_rsp_valid | input | 1 | Returned beat valid |
| mem_rsp_data | input | 32 | Returned beat data |
| cpu_ready | output | 1 | One-cycle release of the CPU |
| cpu_data | output | 32 | Missed word for the CPU |
| probe_valid | input | 1 | Lookup probe valid |
| probe_addr | input | 32 | Lookup probe address |
| probe_stall | output | 1 | Probe hits the line being filled |
| fill_valid | output | 1 | Completed line ready to install |
| fill_tag | output | 20 | Tag of the completed line |
| fill_set | output | 7 | Set index of the completed line |
| fill_line | output | 256 | Completed line, word i at bits 32*i+31:32*i |

## Verification
If the beat counter or the stored critical index is corrupted, the fault first appears as a wrong request address in the cycle after the miss is accepted, or as a ready pulse on the wrong beat. A word slot that is mis-steered shows up in `fill_line` one cycle after the last beat. A broken state register leaves `busy` or `fill_valid` wrong at the end of the fill, and the next miss then issues no requests or extra ones. The scoreboard predicts every request, the CPU word and the completed line from the miss address alone. It compares each of them on the cycle where it is due, with memory latencies and gap patterns that vary from fill to fill.

// File: rtl/cwf_pkg.sv
// Package: shared types for the critical-word-first refill controller.
// Assumes one fill in flight at a time.
package cwf_pkg;
    typedef enum logic {
        FS_IDLE = 1'b0,
        FS_FILL = 1'b1
    } fill_state_t;
endpackage

// File: rtl/cwf_order.sv
// Module: maps a beat count onto a word index within the line.
// In wrapped mode the index is start + count mod LINE_WORDS; in natural
// mode it is the count itself. Assumes LINE_WORDS is a power of two.
module cwf_order #(
    parameter int LINE_WORDS = 8,
    localparam int IDX_W = $clog2(LINE_WORDS)
) (
    input  logic [IDX_W-1:0] start_idx,
    input  logic             wrap_en,
    input  logic [IDX_W-1:0] beat,
    output logic [IDX_W-1:0] word_idx
);
    // Select the wrapped or the plain order; the sum wraps by truncation.
    always_comb begin
        if (wrap_en) word_idx = start_idx + beat;
        else         word_idx = beat;
    end
endmodule

// File: rtl/cwf_linebuf.sv
// Module: line buffer with one register per word, written one beat per
// cycle at an indexed slot. Assumes at most one write per cycle.
module cwf_linebuf #(
    parameter int LINE_WORDS = 8,
    parameter int DATA_W     = 32,
    localparam int IDX_W  = $clog2(LINE_WORDS),
    localparam int LINE_W = LINE_WORDS * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic [LINE_W-1:0] line
);
    for (genvar w = 0; w < LINE_WORDS; w++) begin : g_word
        logic [DATA_W-1:0] word_q;
        // Capture the beat when it targets this slot.
        always_ff @(posedge clk) begin
            if (!rst_n)                              word_q <= '0;
            else if (wr_en && wr_idx == IDX_W'(w))   word_q <= wr_data;
        end
        assign line[w*DATA_W +: DATA_W] = word_q;
    end
endmodule

// File: rtl/cwf_fill_ctrl.sv
// Module: critical-word-first line refill controller.
// Accepts a miss when idle, issues LINE_WORDS word requests on consecutive
// cycles (wrapped from the missed word or in natural order), takes returned
// beats in request order, releases the CPU on the missed word, and presents
// the full line with tag and set one cycle after the last beat.
// Assumes memory returns beats in request order, at most one per cycle.
module cwf_fill_ctrl
    import cwf_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINE_WORDS = 8,
    parameter int SET_W      = 7,
    localparam int BYTE_OFS  = $clog2(DATA_W / 8),
    localparam int IDX_W     = $clog2(LINE_WORDS),
    localparam int OFS_W     = IDX_W + BYTE_OFS,
    localparam int TAG_W     = ADDR_W - OFS_W - SET_W,
    localparam int LADDR_W   = ADDR_W - OFS_W,
    localparam int CNT_W     = IDX_W + 1,
    localparam int LINE_W    = LINE_WORDS * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    input  logic [ADDR_W-1:0] miss_addr,
    input  logic              miss_wrap,
    output logic              busy,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_data,
    input  logic              probe_valid,
    input  logic [ADDR_W-1:0] probe_addr,
    output logic              probe_stall,
    output logic              fill_valid,
    output logic [TAG_W-1:0]  fill_tag,
    output logic [SET_W-1:0]  fill_set,
    output logic [LINE_W-1:0] fill_line
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(LINE_WORDS);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LINE_WORDS - 1);

    fill_state_t        state_q;
    logic [LADDR_W-1:0] line_q;
    logic [IDX_W-1:0]   crit_q;
    logic               wrap_q;
    logic [CNT_W-1:0]   iss_cnt_q;
    logic [CNT_W-1:0]   ret_cnt_q;
    logic [IDX_W-1:0]   iss_idx;
    logic [IDX_W-1:0]   ret_idx;
    logic               req_fire;
    logic               rsp_take;
    logic               last_beat;
    logic               accept;
    logic               unused_low;

    assign unused_low = ^{miss_addr[BYTE_OFS-1:0], probe_addr[OFS_W-1:0]};

    assign busy      = (state_q == FS_FILL);
    assign accept    = !busy && miss_valid;
    assign req_fire  = busy && (iss_cnt_q < CNT_FULL);
    assign rsp_take  = busy && mem_rsp_valid;
    assign last_beat = rsp_take && (ret_cnt_q == CNT_LAST);

    // Word index of the request being issued this cycle.
    cwf_order #(.LINE_WORDS(LINE_WORDS)) u_iss_order (
        .start_idx (crit_q),
        .wrap_en   (wrap_q),
        .beat      (iss_cnt_q[IDX_W-1:0]),
        .word_idx  (iss_idx)
    );

    // Word index of the beat being returned this cycle.
    cwf_order #(.LINE_WORDS(LINE_WORDS)) u_ret_order (
        .start_idx (crit_q),
        .wrap_en   (wrap_q),
        .beat      (ret_cnt_q[IDX_W-1:0]),
        .word_idx  (ret_idx)
    );

    // Store each returned beat at its word position.
    cwf_linebuf #(.LINE_WORDS(LINE_WORDS), .DATA_W(DATA_W)) u_linebuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (rsp_take),
        .wr_idx  (ret_idx),
        .wr_data (mem_rsp_data),
        .line    (fill_line)
    );

    // Fill sequencing: accept, count requests and beats, finish on the last beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= FS_IDLE;
            line_q     <= '0;
            crit_q     <= '0;
            wrap_q     <= 1'b0;
            iss_cnt_q  <= '0;
            ret_cnt_q  <= '0;
            fill_valid <= 1'b0;
        end else begin
            fill_valid <= 1'b0;
            if (accept) begin
                state_q   <= FS_FILL;
                line_q    <= miss_addr[ADDR_W-1:OFS_W];
                crit_q    <= miss_addr[OFS_W-1:BYTE_OFS];
                wrap_q    <= miss_wrap;
                iss_cnt_q <= '0;
                ret_cnt_q <= '0;
            end else if (busy) begin
                if (req_fire) iss_cnt_q <= iss_cnt_q + 1'b1;
                if (rsp_take) ret_cnt_q <= ret_cnt_q + 1'b1;
                if (last_beat) begin
                    state_q    <= FS_IDLE;
                    fill_valid <= 1'b1;
                end
            end
        end
    end

    // Request channel and CPU release.
    assign mem_req_valid = req_fire;
    assign mem_req_addr  = {line_q, iss_idx, {BYTE_OFS{1'b0}}};
    assign cpu_ready     = rsp_take && (ret_idx == crit_q);
    assign cpu_data      = mem_rsp_data;

    // Line identity for install and for stalling lookups of the pending line.
    assign fill_tag    = line_q[LADDR_W-1:SET_W];
    assign fill_set    = line_q[SET_W-1:0];
    assign probe_stall = probe_valid && busy && (probe_addr[ADDR_W-1:OFS_W] == line_q);

    // R2
    cpu_ready_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);
    // R7
    fill_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |-> !busy);
    // R7
    fill_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_beat |=> fill_valid);
    // R8
    busy_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && !busy) |=> busy);
    // R5
    req_in_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> busy);
    // R9
    stall_in_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        probe_stall |-> busy);
endmodule

// File: tb/cwf_fill_ctrl_bench.sv
module cwf_fill_ctrl_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         miss_valid = 1'b0;
    logic [31:0]  miss_addr = '0;
    logic         miss_wrap = 1'b0;
    logic         busy;
    logic         mem_req_valid;
    logic [31:0]  mem_req_addr;
    logic         mem_rsp_valid = 1'b0;
    logic [31:0]  mem_rsp_data = '0;
    logic         cpu_ready;
    logic [31:0]  cpu_data;
    logic         probe_valid = 1'b0;
    logic [31:0]  probe_addr = '0;
    logic         probe_stall;
    logic         fill_valid;
    logic [19:0]  fill_tag;
    logic [6:0]   fill_set;
    logic [255:0] fill_line;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int mem_lat = 2;
    bit gap_en = 1'b0;
    int ready_cnt = 0;
    int fills_seen = 0;

    logic [31:0]  exp_req[$];
    logic [31:0]  exp_cpu[$];
    logic [19:0]  exp_tag[$];
    logic [6:0]   exp_set[$];
    logic [255:0] exp_line[$];
    logic [31:0]  mq_addr[$];
    int           mq_due[$];

    always #4 clk = ~clk;

    cwf_fill_ctrl u_cwf_fill_ctrl (
        .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_addr(miss_addr),
        .miss_wrap(miss_wrap), .busy(busy), .mem_req_valid(mem_req_valid),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .cpu_ready(cpu_ready), .cpu_data(cpu_data),
        .probe_valid(probe_valid), .probe_addr(probe_addr), .probe_stall(probe_stall),
        .fill_valid(fill_valid), .fill_tag(fill_tag), .fill_set(fill_set),
        .fill_line(fill_line)
    );

    function automatic logic [31:0] memw(input logic [31:0] a);
        return (a * 32'h0009_E377) ^ 32'h5A5A_0F0F;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [255:0] act,
                       input logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Driver: offer one miss and push every expected item to the scoreboard.
    task automatic issue_miss(input logic [31:0] addr, input bit wrap);
        logic [255:0] line;
        logic [2:0] crit;
        crit = addr[4:2];
        for (int k = 0; k < 8; k++) begin
            logic [2:0] w;
            w = wrap ? 3'(crit + 3'(k)) : 3'(k);   // R3 / R4 order
            exp_req.push_back({addr[31:5], w, 2'b00});
        end
        for (int i = 0; i < 8; i++) line[i*32 +: 32] = memw({addr[31:5], 3'(i), 2'b00});
        exp_cpu.push_back(memw({addr[31:2], 2'b00}));
        exp_tag.push_back(addr[31:12]);
        exp_set.push_back(addr[11:5]);
        exp_line.push_back(line);
        @(negedge clk);
        miss_valid = 1'b1; miss_addr = addr; miss_wrap = wrap;
        @(negedge clk);
        miss_valid = 1'b0;
        #1 chk(busy === 1'b1, "R8 busy after accept", 256'(busy), 256'(1));
    endtask

    task automatic wait_fill();
        int target;
        target = fills_seen + 1;
        while (fills_seen < target) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // Lower memory model: in-order returns after a latency, optional gaps.
    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            mq_addr.delete(); mq_due.delete();
            mem_rsp_valid = 1'b0;
        end else begin
            if (mem_req_valid) begin
                mq_addr.push_back(mem_req_addr);
                mq_due.push_back(cyc + mem_lat);
            end
            if (mq_addr.size() > 0 && mq_due[0] <= cyc && !(gap_en && (cyc % 3 == 0))) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = memw(mq_addr.pop_front());
                void'(mq_due.pop_front());
            end else begin
                mem_rsp_valid = 1'b0;
            end
        end
    end

    // Monitor: pops expected items as the design produces them.
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            if (mem_req_valid) begin
                if (exp_req.size() == 0)
                    chk(1'b0, "R8 unexpected request", 256'(mem_req_addr), 256'(0));
                else begin
                    logic [31:0] e;
                    e = exp_req.pop_front();
                    chk(mem_req_addr === e, "R1 R3 R4 R5 request order", 256'(mem_req_addr), 256'(e));
                end
            end
            if (cpu_ready) begin
                ready_cnt++;
                if (exp_cpu.size() == 0)
                    chk(1'b0, "R2 unexpected ready", 256'(cpu_data), 256'(0));
                else begin
                    logic [31:0] e;
                    e = exp_cpu.pop_front();
                    chk(cpu_data === e, "R2 R4 critical word", 256'(cpu_data), 256'(e));
                end
            end
            if (fill_valid) begin
                chk(ready_cnt == 1, "R2 one ready before fill", 256'(ready_cnt), 256'(1));
                ready_cnt = 0;
                chk(busy === 1'b0, "R7 busy low at fill", 256'(busy), 256'(0));
                chk(exp_req.size() == 0, "R5 eight requests", 256'(exp_req.size()), 256'(0));
                if (exp_line.size() == 0)
                    chk(1'b0, "R7 unexpected fill", fill_line, 256'(0));
                else begin
                    logic [255:0] el;
                    logic [19:0] et;
                    logic [6:0] es;
                    el = exp_line.pop_front(); et = exp_tag.pop_front(); es = exp_set.pop_front();
                    chk(fill_line === el, "R6 R10 line data", fill_line, el);
                    chk(fill_tag === et, "R7 tag", 256'(fill_tag), 256'(et));
                    chk(fill_set === es, "R7 set", 256'(fill_set), 256'(es));
                end
                fills_seen++;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(busy === 1'b0 && mem_req_valid === 1'b0, "R8 reset idle", 256'({busy, mem_req_valid}), 256'(0));
        chk(cpu_ready === 1'b0 && fill_valid === 1'b0, "R7 reset outputs", 256'({cpu_ready, fill_valid}), 256'(0));

        // R1 R3: wrapped, critical word in the middle
        mem_lat = 2; gap_en = 1'b0;
        issue_miss(32'h1234_5A74, 1'b1);
        wait_fill();
        // R3: wrap from the last word
        issue_miss(32'hCAFE_101C, 1'b1);
        wait_fill();
        // R1: critical word zero
        mem_lat = 5;
        issue_miss(32'h0000_0FE0, 1'b1);
        wait_fill();
        // R4: natural order, critical word 3
        mem_lat = 1;
        issue_miss(32'h8765_432C, 1'b0);
        wait_fill();
        // R10: gaps between beats, wrapped, critical 6
        gap_en = 1'b1; mem_lat = 3;
        issue_miss(32'h0BAD_F0F8, 1'b1);
        wait_fill();
        // R10 R4: gaps, natural order, critical 7
        issue_miss(32'h7777_03FC, 1'b0);
        wait_fill();
        gap_en = 1'b0;

        // R8 R9: miss offered while busy is ignored; probe stalls only the pending line
        mem_lat = 6;
        issue_miss(32'h4444_2208, 1'b1);
        miss_valid = 1'b1; miss_addr = 32'h9999_0000; miss_wrap = 1'b1;
        probe_valid = 1'b1; probe_addr = 32'h4444_221C;
        #1 chk(probe_stall === 1'b1, "R9 stall same line", 256'(probe_stall), 256'(1));
        @(negedge clk);
        miss_valid = 1'b0;
        probe_addr = 32'h4444_2228;
        #1 chk(probe_stall === 1'b0, "R9 no stall other line", 256'(probe_stall), 256'(0));
        probe_valid = 1'b0;
        wait_fill();
        probe_valid = 1'b1; probe_addr = 32'h4444_2200;
        #1 chk(probe_stall === 1'b0, "R9 no stall when idle", 256'(probe_stall), 256'(0));
        probe_valid = 1'b0;
        repeat (4) @(negedge clk);
        #1;
        chk(exp_req.size() == 0 && exp_cpu.size() == 0, "R8 nothing pending",
            256'(exp_req.size() + exp_cpu.size()), 256'(0));
        chk(fills_seen == 7, "R7 fill count", 256'(fills_seen), 256'(7));

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule